// File: doc/BRIEF.md
# Double-Buffered Byte-Loaded Angle Register

This block captures a 16-bit natural-binary angle word arriving over either an 8-bit or a 16-bit bus and presents it as a stable held angle to a downstream sine/cosine generator. Two byte lane registers, one for the upper byte and one for the lower, each load while their own enable is high. A holding register behind them takes the pair of bytes while a load control is high and freezes otherwise. A new word can therefore be assembled byte by byte while the previous angle stays in use.

All three controls act on level. They are sampled on the rising clock edge and are transparent: a lane whose enable is high presents its incoming byte to the holding register in the same cycle. With all three controls high, the input word reaches the held angle after a single clock edge. Each control and each data bit has a drive-valid qualifier. An undriven control reads as 1 and an undriven data bit reads as 0, so a board that leaves everything open gets continuous pass-through, and a system with fewer bits gets zero-filled low bits. On an 8-bit bus the same lines feed both byte inputs: the low byte is loaded first, then the high byte, then the load control is raised. On a 16-bit bus both enables are pulsed together and then the load control is raised.

Top module: `angle_word_latch`

## Requirements
- R1: While the effective upper-lane enable is 1 at a clock edge, the upper lane stores `bus_hi` (angle bits 15..8, bit 15 the MSB weighing 180 degrees). While it is 0, the upper lane keeps its value.
- R2: While the effective lower-lane enable is 1 at a clock edge, the lower lane stores `bus_lo` (angle bits 7..0, bit 0 weighing about 0.0055 degrees). While it is 0, the lower lane keeps its value.
- R3: While the effective load control is 1 at a clock edge, `angle_q` takes {upper lane, lower lane}. Each lane contributes its incoming byte if its enable is also 1, otherwise its stored byte. While the load control is 0, `angle_q` does not change, whatever the lanes do.
- R4: A control whose drive-valid input (`hi_en_drv`, `lo_en_drv`, `load_drv`) is 0 behaves as 1 regardless of its enable input. With all three undriven, the input word flows to `angle_q` continuously.
- R5: A data bit whose drive-valid bit in `data_drv` is 0 reads as 0. `data_drv[15:8]` qualifies `bus_hi[7:0]` and `data_drv[7:0]` qualifies `bus_lo[7:0]`.
- R6: When both enables and the load control are 1 at a clock edge, `angle_q` equals the resolved input word right after that edge.
- R7: A clock edge with `rst_n` low clears both lanes and `angle_q` to zero. A load without new bytes after reset then still gives zero.
- R8: The 8-bit sequence (low lane loaded, then high lane from the same lines, then load) and the 16-bit sequence (both enables together, then load) each produce the assembled word on `angle_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_hi | input | 8 | Upper angle byte (bits 15..8) |
| bus_lo | input | 8 | Lower angle byte (bits 7..0) |
| data_drv | input | 16 | Per-bit drive-valid for {bus_hi, bus_lo}; 0 means undriven |
| hi_en | input | 1 | Upper-lane load enable, level active |
| hi_en_drv | input | 1 | Drive-valid for hi_en; 0 means undriven (reads 1) |
| lo_en | input | 1 | Lower-lane load enable, level active |
| lo_en_drv | input | 1 | Drive-valid for lo_en; 0 means undriven (reads 1) |
| load | input | 1 | Holding-register load control, level active |
| load_drv | input | 1 | Drive-valid for load; 0 means undriven (reads 1) |
| angle_q | output | 16 | Held angle, natural binary |

## Verification
The hardest situation to reach from the ports combines a control that is driven low with a drive-valid bit that is also low: the undriven default must then override the 0 on the enable input. A random walk that only toggles enables never reaches it. The stimulus therefore draws the drive-valid qualifiers independently, weighted so that each is undriven about a quarter of the time, and directed steps set each control low but undriven, one at a time. A second hard case is reloading both lanes while the held angle must stay frozen. A directed sequence covers it by reloading the lanes several times with load low, then loading with both enables low so that only the stored bytes can appear.

// File: rtl/angle_reg_pkg.sv
// Package: shared widths and the resolved control bundle for the angle register.
// Assumes the angle word is split into exactly two equal lanes.
package angle_reg_pkg;

    localparam int unsigned ANGLE_W_DEF = 16;
    localparam int unsigned LANES       = 2;

    // Effective (default-resolved) control levels
    typedef struct packed {
        logic hi;
        logic lo;
        logic load;
    } ctl_t;

endpackage

// File: rtl/angle_ctl_resolve.sv
// Module: resolves each level control against its drive-valid qualifier.
// An undriven control reads as 1. Purely combinational.
module angle_ctl_resolve
    import angle_reg_pkg::*;
(
    input  logic hi_en,
    input  logic hi_en_drv,
    input  logic lo_en,
    input  logic lo_en_drv,
    input  logic load,
    input  logic load_drv,
    output ctl_t ctl
);

    // Undriven control pulls high; driven control passes its level
    always_comb begin
        ctl.hi   = hi_en | ~hi_en_drv;
        ctl.lo   = lo_en | ~lo_en_drv;
        ctl.load = load  | ~load_drv;
    end

endmodule

// File: rtl/angle_bit_resolve.sv
// Module: resolves data bits against per-bit drive-valid; undriven bits read 0.
// Assumes data and drive-valid vectors share the same bit order.
module angle_bit_resolve #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] data,
    input  logic [W-1:0] drv,
    output logic [W-1:0] res
);

    // One gate per bit, built by generate so W can change
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_comb res[b] = drv[b] ? data[b] : 1'b0;
    end

endmodule

// File: rtl/angle_byte_lane.sv
// Module: one level-enabled lane register.
// Stores d on each clock edge while en is high and keeps its value otherwise.
// eff is the transparent view: d while en is high, the stored value otherwise.
// Synchronous active-low reset.
module angle_byte_lane #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] eff
);

    // Lane storage: load while enabled, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d;
    end

    // Transparent lane view seen by the holding register
    always_comb eff = en ? d : q;

    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q)); // R1
    AST_LANE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> q == $past(d)); // R2

endmodule

// File: rtl/angle_hold_reg.sv
// Module: holding register for the assembled angle.
// Loads d on each edge while load is high and is frozen otherwise.
// Synchronous active-low reset to zero.
module angle_hold_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Holding storage: take the lanes while load is high
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q)); // R3
    AST_HOLD_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> q == $past(d)); // R3
    AST_HOLD_RESET: assert property (@(posedge clk)
        !rst_n |=> q == '0); // R7

endmodule

// File: rtl/angle_word_latch.sv
// Module: top of the double-buffered angle register.
// Two byte lanes with level enables feed a holding register with a level load.
// Controls default to 1 and data bits default to 0 when their drive-valid is 0.
// Assumes ANGLE_W is even; the upper lane carries the MSB.
module angle_word_latch
    import angle_reg_pkg::*;
#(
    parameter int unsigned ANGLE_W = ANGLE_W_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ANGLE_W/2-1:0]   bus_hi,
    input  logic [ANGLE_W/2-1:0]   bus_lo,
    input  logic [ANGLE_W-1:0]     data_drv,
    input  logic                   hi_en,
    input  logic                   hi_en_drv,
    input  logic                   lo_en,
    input  logic                   lo_en_drv,
    input  logic                   load,
    input  logic                   load_drv,
    output logic [ANGLE_W-1:0]     angle_q
);

    localparam int unsigned LANE_W = ANGLE_W / LANES;

    ctl_t               ctl;
    logic [ANGLE_W-1:0] word_res;
    logic [LANES-1:0]   lane_en;
    logic [ANGLE_W-1:0] lane_q;
    logic [ANGLE_W-1:0] lane_eff;

    angle_ctl_resolve u_ctl (
        .hi_en     (hi_en),
        .hi_en_drv (hi_en_drv),
        .lo_en     (lo_en),
        .lo_en_drv (lo_en_drv),
        .load      (load),
        .load_drv  (load_drv),
        .ctl       (ctl)
    );

    angle_bit_resolve #(.W(ANGLE_W)) u_bits (
        .data (({bus_hi, bus_lo})),
        .drv  (data_drv),
        .res  (word_res)
    );

    // Lane index 1 is upper, 0 is lower
    always_comb lane_en = {ctl.hi, ctl.lo};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        angle_byte_lane #(.W(LANE_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (lane_en[l]),
            .d     (word_res[l*LANE_W +: LANE_W]),
            .q     (lane_q[l*LANE_W +: LANE_W]),
            .eff   (lane_eff[l*LANE_W +: LANE_W])
        );
    end

    angle_hold_reg #(.W(ANGLE_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ctl.load),
        .d     (lane_eff),
        .q     (angle_q)
    );

    AST_DEFAULT_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_en_drv && !lo_en_drv && !load_drv && (&data_drv))
        |=> angle_q == $past({bus_hi, bus_lo})); // R4
    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.hi && ctl.lo && ctl.load && !data_drv[0]) |=> !angle_q[0]); // R5
    AST_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_en && hi_en_drv && lo_en && lo_en_drv && load && load_drv && (&data_drv))
        |=> angle_q == $past({bus_hi, bus_lo})); // R6
    AST_LANE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.load && !ctl.hi && !ctl.lo)
        |=> angle_q == $past(lane_q)); // R8

endmodule

// File: tb/angle_word_latch_bench.sv
// Bench: directed corner cases plus seeded random stimulus, checked against
// a bench-side model built from the requirements.
module angle_word_latch_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  bus_hi, bus_lo;
    logic [15:0] data_drv;
    logic        hi_en, hi_en_drv, lo_en, lo_en_drv, load, load_drv;
    logic [15:0] angle_q;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Model state
    logic [7:0]  m_hi = '0, m_lo = '0;
    logic [15:0] m_ang = '0;

    always #2 clk = ~clk;

    angle_word_latch u_angle_word_latch (
        .clk(clk), .rst_n(rst_n), .bus_hi(bus_hi), .bus_lo(bus_lo),
        .data_drv(data_drv), .hi_en(hi_en), .hi_en_drv(hi_en_drv),
        .lo_en(lo_en), .lo_en_drv(lo_en_drv), .load(load), .load_drv(load_drv),
        .angle_q(angle_q)
    );

    function automatic logic eff_ctl(input logic en, input logic drv);
        return drv ? en : 1'b1;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: angle_q=%h expected %h", tag, act, exp_v);
        end
    endtask

    // Drive at negedge, let one edge pass, update model, check at next negedge
    task automatic cyc(input string tag, input logic [7:0] h, input logic [7:0] lo_b,
                       input logic he, input logic le, input logic ld,
                       input logic hd, input logic lod, input logic ldd,
                       input logic [15:0] dd);
        logic [7:0] rh, rl;
        logic eh, el, eld;
        bus_hi = h; bus_lo = lo_b; hi_en = he; lo_en = le; load = ld;
        hi_en_drv = hd; lo_en_drv = lod; load_drv = ldd; data_drv = dd;
        @(posedge clk);
        rh = h & dd[15:8];
        rl = lo_b & dd[7:0];
        eh = eff_ctl(he, hd); el = eff_ctl(le, lod); eld = eff_ctl(ld, ldd);
        if (eh) m_hi = rh;
        if (el) m_lo = rl;
        if (eld) m_ang = {m_hi, m_lo};
        @(negedge clk);
        chk(tag, angle_q, m_ang);
    endtask

    // Watchdog
    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: angle_q=%h expected run to finish", angle_q);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd20517);
        rst_n = 1'b0;
        bus_hi = 8'hA5; bus_lo = 8'h5A; data_drv = '1;
        hi_en = 1; lo_en = 1; load = 1; hi_en_drv = 1; lo_en_drv = 1; load_drv = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 reset clears", angle_q, 16'h0000);
        rst_n = 1'b1;

        // R7: load with enables low after reset gives zero
        cyc("R7 load empty lanes", 8'hFF, 8'hFF, 0, 0, 1, 1, 1, 1, '1);
        // R6: all high flows through in one edge
        cyc("R6 flow", 8'h12, 8'h34, 1, 1, 1, 1, 1, 1, '1);
        chk("R6 flow value", angle_q, 16'h1234);
        // R3: reload lanes with load low, angle frozen
        cyc("R3 freeze a", 8'hBE, 8'hEF, 1, 1, 0, 1, 1, 1, '1);
        cyc("R3 freeze b", 8'h77, 8'h66, 1, 0, 0, 1, 1, 1, '1);
        cyc("R3 freeze c", 8'h00, 8'h99, 0, 1, 0, 1, 1, 1, '1);
        chk("R3 frozen value", angle_q, 16'h1234);
        // R8/R3: load stored lanes only
        cyc("R8 stored lanes", 8'h11, 8'h22, 0, 0, 1, 1, 1, 1, '1);
        chk("R8 stored value", angle_q, 16'h7799);
        // R1: upper lane only
        cyc("R1 upper only", 8'hC3, 8'h3C, 1, 0, 1, 1, 1, 1, '1);
        chk("R1 upper value", angle_q, 16'hC399);
        // R2: lower lane only
        cyc("R2 lower only", 8'h01, 8'h80, 0, 1, 1, 1, 1, 1, '1);
        chk("R2 lower value", angle_q, 16'hC380);
        // R4: each control driven low but undriven acts as 1
        cyc("R4 hi default", 8'h4D, 8'h00, 0, 0, 1, 0, 1, 1, '1);
        chk("R4 hi default value", angle_q, 16'h4D80);
        cyc("R4 lo default", 8'h00, 8'hE2, 0, 0, 1, 1, 0, 1, '1);
        chk("R4 lo default value", angle_q, 16'h4DE2);
        cyc("R4 load default", 8'h5F, 8'hF5, 1, 1, 0, 1, 1, 0, '1);
        chk("R4 load default value", angle_q, 16'h5FF5);
        cyc("R4 all undriven", 8'h9A, 8'hBC, 0, 0, 0, 0, 0, 0, '1);
        chk("R4 all undriven value", angle_q, 16'h9ABC);
        // R5: only 12 bits driven, low nibble zero-filled
        cyc("R5 zero fill", 8'hFF, 8'hFF, 1, 1, 1, 1, 1, 1, 16'hFFF0);
        chk("R5 zero fill value", angle_q, 16'hFFF0);
        // R8: 8-bit bus sequence, same lines feed both lanes
        cyc("R8 byte bus idle", 8'h00, 8'h00, 0, 0, 0, 1, 1, 1, '1);
        cyc("R8 byte bus low", 8'h6B, 8'h6B, 0, 1, 0, 1, 1, 1, '1);
        cyc("R8 byte bus high", 8'h2C, 8'h2C, 1, 0, 0, 1, 1, 1, '1);
        chk("R8 held before load", angle_q, 16'hFFF0);
        cyc("R8 byte bus load", 8'h00, 8'h00, 0, 0, 1, 1, 1, 1, '1);
        chk("R8 byte bus value", angle_q, 16'h2C6B);
        // R8: 16-bit bus sequence
        cyc("R8 word bus enables", 8'h80, 8'h01, 1, 1, 0, 1, 1, 1, '1);
        cyc("R8 word bus load", 8'h00, 8'h00, 0, 0, 1, 1, 1, 1, '1);
        chk("R8 word bus value", angle_q, 16'h8001);

        // Random walk over all controls and qualifiers
        for (int i = 0; i < 600; i++) begin
            logic [15:0] dd;
            dd = (($urandom % 4) == 0) ? 16'($urandom) : 16'hFFFF;
            cyc("R1 R2 R3 R4 R5 random",
                8'($urandom), 8'($urandom),
                1'($urandom), 1'($urandom), (($urandom % 3) == 0),
                (($urandom % 4) != 0), (($urandom % 4) != 0), (($urandom % 4) != 0),
                dd);
        end

        // R7: reset mid-run clears everything
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        m_hi = '0; m_lo = '0; m_ang = '0;
        chk("R7 mid-run reset", angle_q, 16'h0000);
        cyc("R7 lanes cleared", 8'hAA, 8'hAA, 0, 0, 1, 1, 1, 1, '1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule